// File: doc/BRIEF.md
# Segment Register Selection Unit

This unit sits on the address side of a load/store and fetch path. It takes a 64-bit effective address and reads the segment number from its three most significant bits. It adds the base held in the selected segment register to the remaining 61-bit offset and returns the linear address one cycle later. A load or store can therefore pick its segment purely through the pointer value it holds, and no instruction field is involved. Because the selector bits never reach the linear address, the eight selector banks alias the same offset space. Instruction fetches ignore the address bits and always use the code segment.

The unit holds eight segment base registers behind a privileged write port. For requests marked as user mode, a permission check lets through only the data (selector 1), stack (selector 6) and code (selector 7) segments. Any other selector returns a fault. This includes selector 5, which is kept for operating-system variables.

Requests and responses are valid/ready streams. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high whenever the output register is empty or the consumer is taking its content in that cycle. While `rsp_valid` is high and `rsp_ready` is low, the response is held unchanged. The requester must keep a request stable until it is accepted.

Top module: `seg_sel_unit`

## Requirements
- R1: After reset, `rsp_valid` and `wr_fault` are low and every segment base is zero.
- R2: The selector is `req_addr[63:61]` for data accesses. When `req_fetch` is 1 the selector is 7 (code), whatever the address bits are.
- R3: An accepted request produces, on the next clock edge, `rsp_lin_addr` = base[selector] + zero-extended `req_addr[60:0]`, modulo 2^64.
- R4: The selector bits take no part in the sum. Two addresses that differ only in bits 63:61 and select bases of equal value give the same linear address.
- R5: When `req_user` is 1 and the selector is not 1, 6 or 7 (so selector 5, the OS segment, among others), the response has `rsp_fault`=1 and `rsp_ok`=0. Otherwise `rsp_ok`=1 and `rsp_fault`=0. Both appear with the registered address.
- R6: A request with `req_user`=0 never faults, for any selector.
- R7: A write with `wr_en`=1 and `wr_user`=0 replaces base[`wr_sel`] from the next edge on. A request accepted in the same cycle as the write still uses the old base.
- R8: A write with `wr_user`=1 changes no base. `wr_fault` is high for exactly the one cycle after it.
- R9: `req_ready` = !`rsp_valid` || `rsp_ready`. While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid`, `rsp_lin_addr`, `rsp_ok` and `rsp_fault` hold their values.
- R10: A user-mode fetch (`req_fetch`=1, `req_user`=1) never faults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_addr | input | 64 | Effective address; bits 63:61 select the segment |
| req_user | input | 1 | 1 = user-mode access |
| req_fetch | input | 1 | 1 = instruction fetch (forces selector 7) |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_lin_addr | output | 64 | Linear address |
| rsp_ok | output | 1 | Access permitted |
| rsp_fault | output | 1 | Protection fault |
| wr_en | input | 1 | Segment base write strobe |
| wr_user | input | 1 | 1 = write attempted from user mode |
| wr_sel | input | 3 | Segment register written |
| wr_base | input | 64 | New base value |
| wr_fault | output | 1 | Pulse: a user-mode write was refused |

## Verification
Two functions can act in the same cycle: a base write, and the acceptance of an address request that selects the register being written. The bench issues such a request together with a supervisor write to the same selector. It expects the old base on that response and the new base on a request one cycle later. A user-mode write is also placed next to a request, to confirm that the base is unchanged and that `wr_fault` rises independently of the response stream. A behavioural model predicts every output on every clock. That model also covers random back-pressure, where held responses overlap with writes.

// File: rtl/seg_pkg.sv
package seg_pkg;
  localparam int unsigned DEF_ADDR_W = 64;
  localparam int unsigned DEF_SEL_W  = 3;

  typedef enum logic {
    PRIV_SUPER = 1'b0,
    PRIV_USER  = 1'b1
  } priv_e;

  // selectors reachable in user mode: data(1), stack(6), code(7)
  localparam logic [7:0] DEF_USER_MASK = 8'b1100_0010;
  localparam logic [2:0] DEF_CODE_SEL  = 3'd7;
endpackage

// File: rtl/seg_regfile.sv
module seg_regfile #(
  parameter int unsigned ADDR_W = seg_pkg::DEF_ADDR_W,
  parameter int unsigned SEL_W  = seg_pkg::DEF_SEL_W,
  localparam int unsigned NSEG  = 1 << SEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  seg_pkg::priv_e    wr_priv,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [ADDR_W-1:0] wr_base,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic [ADDR_W-1:0] rd_base,
  output logic              wr_fault
);
  logic [NSEG-1:0][ADDR_W-1:0] base_q;
  logic                        wr_ok;

  assign wr_ok = wr_en && (wr_priv == seg_pkg::PRIV_SUPER);

  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    always_ff @(posedge clk) begin
      if (!rst_n)
        base_q[g] <= '0;
      else if (wr_ok && (wr_sel == SEL_W'(g)))
        base_q[g] <= wr_base;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) wr_fault <= 1'b0;
    else        wr_fault <= wr_en && (wr_priv == seg_pkg::PRIV_USER);
  end

  assign rd_base = base_q[rd_sel];

  p_user_write_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_priv == seg_pkg::PRIV_USER) |=> $stable(base_q));
  p_fault_after_user_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_priv == seg_pkg::PRIV_USER) |=> wr_fault);
  p_no_spurious_fault_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en || wr_priv == seg_pkg::PRIV_SUPER) |=> !wr_fault);
endmodule

// File: rtl/seg_perm.sv
module seg_perm #(
  parameter int unsigned SEL_W     = seg_pkg::DEF_SEL_W,
  localparam int unsigned NSEG     = 1 << SEL_W,
  parameter logic [NSEG-1:0] USER_MASK = seg_pkg::DEF_USER_MASK
) (
  input  logic [SEL_W-1:0] sel,
  input  seg_pkg::priv_e   priv,
  output logic             fault
);
  logic [NSEG-1:0] sel_dec;

  always_comb begin
    sel_dec = '0;
    sel_dec[sel] = 1'b1;
  end

  assign fault = (priv == seg_pkg::PRIV_USER) && ((sel_dec & USER_MASK) == '0);
endmodule

// File: rtl/seg_out_stage.sv
module seg_out_stage #(
  parameter int unsigned ADDR_W = seg_pkg::DEF_ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic              in_fault,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_ok,
  output logic              out_fault
);
  logic              v_q;
  logic              f_q;
  logic [ADDR_W-1:0] a_q;

  assign in_ready = !v_q || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q <= 1'b0;
      f_q <= 1'b0;
    end else if (in_ready) begin
      v_q <= in_valid;
      f_q <= in_valid && in_fault;
    end
  end

  always_ff @(posedge clk) begin
    if (in_ready && in_valid) a_q <= in_addr;
  end

  assign out_valid = v_q;
  assign out_addr  = a_q;
  assign out_fault = v_q && f_q;
  assign out_ok    = v_q && !f_q;

  p_fault_blocks_ok_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_fault |-> !out_ok);
  p_hold_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid);
  p_hold_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> ($stable(out_addr) && $stable(out_fault)));
endmodule

// File: rtl/seg_sel_unit.sv
module seg_sel_unit #(
  parameter int unsigned ADDR_W = seg_pkg::DEF_ADDR_W,
  parameter int unsigned SEL_W  = seg_pkg::DEF_SEL_W,
  localparam int unsigned NSEG  = 1 << SEL_W,
  localparam int unsigned OFF_W = ADDR_W - SEL_W,
  parameter logic [NSEG-1:0]  USER_MASK = seg_pkg::DEF_USER_MASK,
  parameter logic [SEL_W-1:0] CODE_SEL  = seg_pkg::DEF_CODE_SEL
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_user,
  input  logic              req_fetch,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [ADDR_W-1:0] rsp_lin_addr,
  output logic              rsp_ok,
  output logic              rsp_fault,
  input  logic              wr_en,
  input  logic              wr_user,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [ADDR_W-1:0] wr_base,
  output logic              wr_fault
);
  import seg_pkg::*;

  logic [SEL_W-1:0]  sel;
  logic [ADDR_W-1:0] offset;
  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] lin;
  logic              perm_fault;
  priv_e             req_priv;
  priv_e             wr_priv;

  assign req_priv = req_user ? PRIV_USER : PRIV_SUPER;
  assign wr_priv  = wr_user  ? PRIV_USER : PRIV_SUPER;

  assign sel    = req_fetch ? CODE_SEL : req_addr[ADDR_W-1 -: SEL_W];
  assign offset = {{SEL_W{1'b0}}, req_addr[OFF_W-1:0]};
  assign lin    = base + offset;

  seg_regfile #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) i_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_priv(wr_priv),
    .wr_sel(wr_sel), .wr_base(wr_base), .rd_sel(sel), .rd_base(base),
    .wr_fault(wr_fault)
  );

  seg_perm #(.SEL_W(SEL_W), .USER_MASK(USER_MASK)) i_perm (
    .sel(sel), .priv(req_priv), .fault(perm_fault)
  );

  seg_out_stage #(.ADDR_W(ADDR_W)) i_out (
    .clk(clk), .rst_n(rst_n),
    .in_valid(req_valid), .in_ready(req_ready),
    .in_addr(lin), .in_fault(perm_fault),
    .out_valid(rsp_valid), .out_ready(rsp_ready),
    .out_addr(rsp_lin_addr), .out_ok(rsp_ok), .out_fault(rsp_fault)
  );

  p_super_never_faults_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_user) |=> (rsp_valid && !rsp_fault));
  p_user_fetch_ok_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_fetch) |=> (rsp_valid && rsp_ok));
  p_os_segment_blocked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_user && !req_fetch && req_addr[ADDR_W-1 -: SEL_W] == SEL_W'(5))
      |=> rsp_fault);
  p_ready_rule_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!rsp_valid || rsp_ready) |-> req_ready);
endmodule

// File: tb/test_seg_sel_unit.sv
`timescale 1ns/1ps
module test_seg_sel_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_user = 1'b0, req_fetch = 1'b0;
  logic [63:0] req_addr = '0;
  logic        req_ready;
  logic        rsp_valid, rsp_ok, rsp_fault;
  logic        rsp_ready = 1'b1;
  logic [63:0] rsp_lin_addr;
  logic        wr_en = 1'b0, wr_user = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [63:0] wr_base = '0;
  logic        wr_fault;

  always #2.5 clk = ~clk;

  seg_sel_unit i_seg_sel_unit (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_user(req_user), .req_fetch(req_fetch),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_lin_addr(rsp_lin_addr),
    .rsp_ok(rsp_ok), .rsp_fault(rsp_fault),
    .wr_en(wr_en), .wr_user(wr_user), .wr_sel(wr_sel), .wr_base(wr_base),
    .wr_fault(wr_fault)
  );

  int    n_tests = 0;
  int    n_fail  = 0;
  string tag = "R1";
  bit    done = 1'b0;

  // reference model
  logic [63:0] mbase [8];
  logic        exp_v = 1'b0, exp_f = 1'b0, exp_wf = 1'b0, acc_last = 1'b0;
  logic [63:0] exp_a = '0;

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    logic       rdy;
    logic [2:0] s;
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) mbase[i] = '0;
      exp_v = 0; exp_f = 0; exp_wf = 0; acc_last = 0;
    end else begin
      rdy = !exp_v || rsp_ready;
      acc_last = req_valid && rdy;
      if (rdy) begin
        exp_v = req_valid;
        if (req_valid) begin
          s = req_fetch ? 3'd7 : req_addr[63:61];
          exp_a = mbase[s] + {3'b000, req_addr[60:0]};
          exp_f = req_user && !(s == 3'd1 || s == 3'd6 || s == 3'd7);
        end
      end
      if (wr_en && !wr_user) mbase[wr_sel] = wr_base;
      exp_wf = wr_en && wr_user;
    end
  end

  // compare one ns after every rising edge
  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      chk(rsp_valid == exp_v, "rsp_valid", 64'(rsp_valid), 64'(exp_v));
      chk(req_ready == (!exp_v || rsp_ready), "req_ready", 64'(req_ready), 64'(!exp_v || rsp_ready));
      chk(wr_fault == exp_wf, "wr_fault", 64'(wr_fault), 64'(exp_wf));
      if (exp_v) begin
        chk(rsp_lin_addr == exp_a, "rsp_lin_addr", rsp_lin_addr, exp_a);
        chk(rsp_fault == exp_f, "rsp_fault", 64'(rsp_fault), 64'(exp_f));
        chk(rsp_ok == !exp_f, "rsp_ok", 64'(rsp_ok), 64'(!exp_f));
      end
    end
  end

  task automatic idle();
    @(negedge clk);
    req_valid = 0; wr_en = 0; rsp_ready = 1;
  endtask

  task automatic req(input logic [63:0] a, input bit u, input bit f);
    @(negedge clk);
    req_valid = 1; req_addr = a; req_user = u; req_fetch = f; wr_en = 0; rsp_ready = 1;
  endtask

  task automatic wr(input logic [2:0] s, input logic [63:0] b, input bit u);
    @(negedge clk);
    req_valid = 0; wr_en = 1; wr_sel = s; wr_base = b; wr_user = u; rsp_ready = 1;
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    tag = "R1";
    chk(rsp_valid == 0, "rsp_valid in reset", 64'(rsp_valid), 64'd0);
    chk(wr_fault == 0, "wr_fault in reset", 64'(wr_fault), 64'd0);
    @(negedge clk); rst_n = 1;
    for (int s = 0; s < 8; s++) req({3'(s), 61'h123_4567}, 0, 0);
    idle();

    tag = "R3";
    for (int s = 0; s < 8; s++) wr(3'(s), 64'h1000_0000_0000 * (s + 1), 0);
    for (int s = 0; s < 8; s++) req({3'(s), 61'h0ABC}, 0, 0);
    wr(3'd2, 64'hFFFF_FFFF_FFFF_FFF0, 0);
    req({3'd2, 61'h20}, 0, 0);                        // wraps to 0x10
    idle();

    tag = "R2";
    req({3'd3, 61'h55}, 0, 1);                        // fetch uses code base
    req({3'd0, 61'h55}, 0, 1);
    req({3'd4, 61'h55}, 0, 0);
    idle();

    tag = "R4";
    wr(3'd0, 64'h777, 0); wr(3'd1, 64'h777, 0);
    req({3'd0, 61'h1F00}, 0, 0);
    req({3'd1, 61'h1F00}, 0, 0);
    idle();

    tag = "R5";
    for (int s = 0; s < 8; s++) req({3'(s), 61'h40}, 1, 0);
    req({3'd5, 61'h8}, 1, 0);                         // OS segment
    idle();

    tag = "R6";
    for (int s = 0; s < 8; s++) req({3'(s), 61'h44}, 0, 0);
    idle();

    tag = "R10";
    for (int s = 0; s < 8; s++) req({3'(s), 61'h48}, 1, 1);
    idle();

    tag = "R7";                                       // write and use in same cycle
    @(negedge clk);
    req_valid = 1; req_addr = {3'd6, 61'h10}; req_user = 0; req_fetch = 0;
    wr_en = 1; wr_user = 0; wr_sel = 3'd6; wr_base = 64'hABCD_0000;
    req({3'd6, 61'h10}, 0, 0);
    idle();

    tag = "R8";
    @(negedge clk);
    req_valid = 1; req_addr = {3'd6, 61'h20}; req_user = 1; req_fetch = 0;
    wr_en = 1; wr_user = 1; wr_sel = 3'd6; wr_base = 64'h5555;
    req({3'd6, 61'h20}, 1, 0);
    idle(); idle();

    tag = "R9";                                       // random traffic with back-pressure
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      if (!(req_valid && !acc_last)) begin
        req_valid = ($urandom % 3) != 0;
        req_addr  = {$urandom, $urandom};
        req_user  = $urandom % 2;
        req_fetch = ($urandom % 5) == 0;
      end
      rsp_ready = ($urandom % 3) != 0;
      wr_en   = ($urandom % 6) == 0;
      wr_user = ($urandom % 3) == 0;
      wr_sel  = 3'($urandom);
      wr_base = {$urandom, $urandom};
    end
    idle(); idle();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule